// File: doc/BRIEF.md
# Serial Data Link Receive Deframer

This block sits behind a serial data link bit slot and turns the received bits into bytes for a receive FIFO. A strobe marks each cycle that carries a link bit. A two-bit mode input picks one of four behaviours. Two are bit-oriented framing modes: the block hunts for flags, deletes stuffed zeros, spots aborts and closes frames. One of them also checks and strips a 16-bit CRC trailer. The other two modes are transparent: every bit is packed into a byte of eight or six bits, and nothing is searched for.

Each byte that has to be stored leaves the block as a one-cycle write request. The request carries the byte, an end-of-frame tag and a two-bit status. The FIFO drives a full flag back to the block. A frame event pulses with every end-of-frame entry, and an overflow event pulses whenever a byte is dropped because the FIFO is full. The mode must only be changed while the enable is low. Dropping the enable clears all deframing state.

Top module: `dl_rx_deframer`

## Requirements
- R1: The `mode` input is decoded as follows: 00 selects framed with CRC check, 01 selects framed with no CRC, 10 selects transparent 8-bit, and 11 selects transparent 6-bit. In the transparent 8-bit mode, each eight accepted bits form one byte, with the first bit received placed at bit 0. The byte is written with `wr_eof`=0 and `wr_stat`=00.
- R2: In the transparent 6-bit mode, each six accepted bits form one byte, with the first bit at bit 0 and bits 7:6 written as zero.
- R3: In the framed modes, the pattern 01111110 is a flag. Flags open and close frames and never reach the FIFO. A frame with no bits between its flags writes nothing. Two flags may share one zero.
- R4: In the framed modes, a zero that follows five ones inside a frame is deleted from the data.
- R5: In framed-with-CRC mode, the last two bytes before the closing flag are the trailer and are not written. The last byte before the trailer is written with `wr_eof`=1. Its status is 00 (good) when a reflected CRC-16 (polynomial 0x8408, preset 0xFFFF, run over data plus trailer, first bit first) ends at 0xF0B8.
- R6: In framed-with-CRC mode, a complete frame whose CRC does not end at 0xF0B8 tags its last data byte with status 01.
- R7: In framed-without-CRC mode, every byte between the flags is written. The last byte is tagged `wr_eof`=1 with status 00.
- R8: Seven consecutive ones inside a frame are an abort. The block writes one entry with data 0x00, `wr_eof`=1 and status 10, and then hunts for the next flag.
- R9: A frame that closes with bits left over after its last whole byte is bad. So is a frame in CRC mode that holds fewer than three bytes. Either one writes a single entry with data 0x00, `wr_eof`=1 and status 11.
- R10: When a write is due while `fifo_full` is high, `wr_en` stays low and `ev_ovfl` pulses for one cycle. The byte is lost.
- R11: While `rx_en` is low, no write and no event is produced. Bits accepted before the enable was cleared are discarded.
- R12: A write request appears in the cycle after the bit that completes it. `ev_frame` pulses together with every `wr_eof` entry. After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable; low clears deframing state |
| mode | input | 2 | Mode select (see R1) |
| bit_vld | input | 1 | Current cycle carries a link bit |
| bit_in | input | 1 | Link bit |
| fifo_full | input | 1 | Receive FIFO cannot accept a write |
| wr_en | output | 1 | FIFO write strobe |
| wr_data | output | 8 | Byte to write |
| wr_eof | output | 1 | Entry closes a frame |
| wr_stat | output | 2 | Frame status: 00 good, 01 CRC error, 10 abort, 11 short or ragged |
| ev_frame | output | 1 | Frame event, one pulse per end-of-frame entry |
| ev_ovfl | output | 1 | Overflow event, one pulse per dropped byte |

## Verification
The assertions hold on every cycle. They check that a write never happens alongside an overflow or while the FIFO is full, that nothing leaves the block in the cycle after it was disabled, that transparent entries never carry a frame tag, that 6-bit bytes keep their top bits clear, and that abort and short entries carry zero data with an end tag. The bench scenarios are the only place to show the rest: that flags, stuffed zeros and trailers are really stripped, that CRC results are judged correctly, that abort recovery works, and that every byte value packs correctly in both transparent widths.

// File: rtl/dl_rx_deframer.sv
module dl_rx_deframer #(
  parameter logic [15:0] CRC_POLY    = 16'h8408,
  parameter logic [15:0] CRC_PRESET  = 16'hFFFF,
  parameter logic [15:0] CRC_RESIDUE = 16'hF0B8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic [1:0] mode,
  input  logic       bit_vld,
  input  logic       bit_in,
  input  logic       fifo_full,
  output logic       wr_en,
  output logic [7:0] wr_data,
  output logic       wr_eof,
  output logic [1:0] wr_stat,
  output logic       ev_frame,
  output logic       ev_ovfl
);
  localparam logic [1:0] ST_GOOD = 2'd0, ST_BADCRC = 2'd1, ST_ABORT = 2'd2, ST_SHORT = 2'd3;

  logic [2:0]  ones;
  logic        in_frame;
  logic [5:0]  dly;
  logic [2:0]  dcnt;
  logic [7:0]  sr;
  logic [3:0]  bcnt;
  logic [7:0]  h0, h1, h2;
  logic [1:0]  hc;
  logic [15:0] crc;
  logic        req, reof;
  logic [7:0]  rdata;
  logic [1:0]  rstat;

  wire hd       = ~mode[1];
  wire is_flag  = hd & ~bit_in & (ones == 3'd6);
  wire is_abort = hd &  bit_in & (ones == 3'd6);
  wire is_stuff = hd & ~bit_in & (ones == 3'd5);
  wire is_sixth = hd &  bit_in & (ones == 3'd5);
  wire dpush    = hd & in_frame & ~is_flag & ~is_abort & ~is_stuff & ~is_sixth;

  wire        asm_v  = mode[1] | (dpush & (dcnt == 3'd6));
  wire        asm_b  = mode[1] ? bit_in : dly[5];
  wire [7:0]  nsr    = {asm_b, sr[7:1]};
  wire [3:0]  blast  = (mode == 2'b11) ? 4'd5 : 4'd7;
  wire        bdone  = asm_v & (bcnt == blast);
  wire [7:0]  bval   = (mode == 2'b11) ? {2'b00, nsr[7:2]} : nsr;
  wire [15:0] crc_n  = {1'b0, crc[15:1]} ^ ((crc[0] ^ asm_b) ? CRC_POLY : 16'h0000);
  wire        cls_ok = (bcnt == 4'd0) & (mode[0] ? (hc != 2'd0) : (hc == 2'd3));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones <= '0; in_frame <= 1'b0; dly <= '0; dcnt <= '0; sr <= '0; bcnt <= '0;
      h0 <= '0; h1 <= '0; h2 <= '0; hc <= '0; crc <= CRC_PRESET;
      req <= 1'b0; reof <= 1'b0; rdata <= '0; rstat <= ST_GOOD;
    end else begin
      req <= 1'b0;
      if (!rx_en) begin
        in_frame <= 1'b0; ones <= '0; dcnt <= '0; bcnt <= '0; hc <= '0;
      end else if (bit_vld) begin
        if (hd) ones <= bit_in ? ((ones == 3'd7) ? ones : ones + 3'd1) : 3'd0;
        if (dpush) begin
          dly <= {dly[4:0], bit_in};
          if (dcnt != 3'd6) dcnt <= dcnt + 3'd1;
        end
        if (asm_v) begin
          sr   <= nsr;
          crc  <= crc_n;
          bcnt <= bdone ? 4'd0 : bcnt + 4'd1;
        end
        if (bdone) begin
          if (mode[1]) begin
            req <= 1'b1; rdata <= bval; reof <= 1'b0; rstat <= ST_GOOD;
          end else begin
            h0 <= bval; h1 <= h0; h2 <= h1;
            if (hc != 2'd3) hc <= hc + 2'd1;
            if (mode[0] ? (hc != 2'd0) : (hc == 2'd3)) begin
              req <= 1'b1; rdata <= mode[0] ? h0 : h2; reof <= 1'b0; rstat <= ST_GOOD;
            end
          end
        end
        if (is_flag | is_abort) begin
          in_frame <= is_flag;
          dcnt <= '0; bcnt <= '0; hc <= '0; crc <= CRC_PRESET;
          if (is_abort & in_frame) begin
            req <= 1'b1; rdata <= 8'h00; reof <= 1'b1; rstat <= ST_ABORT;
          end else if (is_flag & in_frame & ((hc != 2'd0) | (bcnt != 4'd0))) begin
            req  <= 1'b1; reof <= 1'b1;
            rdata <= cls_ok ? (mode[0] ? h0 : h2) : 8'h00;
            rstat <= !cls_ok ? ST_SHORT :
                     (!mode[0] && crc != CRC_RESIDUE) ? ST_BADCRC : ST_GOOD;
          end
        end
      end
    end
  end

  assign wr_en    = req & rx_en & ~fifo_full;
  assign ev_ovfl  = req & rx_en &  fifo_full;
  assign ev_frame = req & rx_en &  reof;
  assign wr_data  = rdata;
  assign wr_eof   = reof;
  assign wr_stat  = rstat;

  a_r10_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !fifo_full && !ev_ovfl);
  a_r11_quiet_after_disable: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rx_en) |-> !wr_en && !ev_ovfl && !ev_frame);
  a_r1_transparent_untagged: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode[1]) |-> !wr_eof && wr_stat == ST_GOOD);
  a_r2_six_bit_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode == 2'b11) |-> wr_data[7:6] == 2'b00);
  a_r8_r9_error_entry_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_stat[1]) |-> wr_eof && wr_data == 8'h00);
  a_r12_status_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_stat != ST_GOOD) |-> wr_eof);
endmodule

// File: tb/tb_dl_rx_deframer.sv
module tb_dl_rx_deframer;
  logic clk = 1'b0, rst_n = 1'b0, rx_en = 1'b0, bit_vld = 1'b0, bit_in = 1'b0, fifo_full = 1'b0;
  logic [1:0] mode = 2'b00;
  logic wr_en, wr_eof, ev_frame, ev_ovfl;
  logic [7:0] wr_data;
  logic [1:0] wr_stat;

  always #2 clk = ~clk;

  dl_rx_deframer dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .mode(mode), .bit_vld(bit_vld), .bit_in(bit_in),
    .fifo_full(fifo_full), .wr_en(wr_en), .wr_data(wr_data), .wr_eof(wr_eof), .wr_stat(wr_stat),
    .ev_frame(ev_frame), .ev_ovfl(ev_ovfl));

  int checks = 0, errors = 0, qn = 0, novf = 0, nfr = 0, tx_ones = 0;
  logic [7:0] qd [0:511];
  logic       qe [0:511];
  logic [1:0] qs [0:511];
  logic [7:0] pl [0:15];

  always @(negedge clk) begin
    if (wr_en && qn < 512) begin
      qd[qn] = wr_data; qe[qn] = wr_eof; qs[qn] = wr_stat; qn++;
    end
    if (ev_ovfl) novf++;
    if (ev_frame) nfr++;
  end

  task automatic chk(input string r, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic sb(input logic b);
    bit_vld = 1'b1; bit_in = b;
    @(negedge clk);
    bit_vld = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr();
    qn = 0; novf = 0; nfr = 0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    rx_en = 1'b0; @(negedge clk);
    mode = m; rx_en = 1'b1; @(negedge clk);
  endtask

  task automatic tx_raw(input logic [7:0] v, input int nb);
    for (int i = 0; i < nb; i++) sb(v[i]);
  endtask

  task automatic tx_flag();
    tx_raw(8'h7E, 8);
    tx_ones = 0;
  endtask

  task automatic tx_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      sb(v[i]);
      tx_ones = v[i] ? tx_ones + 1 : 0;
      if (tx_ones == 5) begin sb(1'b0); tx_ones = 0; end
    end
  endtask

  function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] v);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      logic fb = r[0] ^ v[i];
      r = r >> 1;
      if (fb) r = r ^ 16'h8408;
    end
    return r;
  endfunction

  task automatic send_frame(input int n, input bit fcs, input logic [15:0] flip);
    logic [15:0] c = 16'hFFFF, f;
    tx_flag();
    for (int i = 0; i < n; i++) begin tx_byte(pl[i]); c = crc_upd(c, pl[i]); end
    if (fcs) begin
      f = ~c ^ flip;
      tx_byte(f[7:0]); tx_byte(f[15:8]);
    end
    tx_flag();
    idle(2);
  endtask

  task automatic check_frame(input string r, input int n, input int st);
    chk(r, "entry count", qn, n);
    for (int i = 0; i < n && i < qn; i++) begin
      chk(r, $sformatf("data[%0d]", i), qd[i], pl[i]);
      chk(r, $sformatf("eof[%0d]", i), qe[i], (i == n - 1) ? 1 : 0);
      chk(r, $sformatf("stat[%0d]", i), qs[i], (i == n - 1) ? st : 0);
    end
    chk("R12", "frame events", nfr, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    idle(3);
    chk("R12", "reset wr_en", wr_en, 0);
    chk("R12", "reset ev_frame", ev_frame, 0);
    chk("R12", "reset ev_ovfl", ev_ovfl, 0);
    rst_n = 1'b1;
    idle(2);

    // R12 latency, R1 transparent 8-bit
    set_mode(2'b10); clr();
    tx_raw(8'h3C, 7);
    chk("R12", "no write before last bit", wr_en, 0);
    sb(1'b0);
    chk("R12", "write one cycle after last bit", wr_en, 1);
    chk("R12", "latency data", wr_data, 8'h3C);
    idle(2);

    clr();
    for (int v = 0; v < 256; v++) tx_raw(8'(v), 8);
    idle(2);
    chk("R1", "pack8 count", qn, 256);
    for (int v = 0; v < 256; v++) begin
      chk("R1", $sformatf("pack8 byte %0d", v), qd[v], v);
      chk("R1", "pack8 eof", qe[v], 0);
    end

    set_mode(2'b11); clr();
    for (int v = 0; v < 64; v++) tx_raw(8'(v), 6);
    idle(2);
    chk("R2", "pack6 count", qn, 64);
    for (int v = 0; v < 64; v++) chk("R2", $sformatf("pack6 byte %0d", v), qd[v], v);

    // R5 with R4 payloads containing ones runs and flag-like bytes
    set_mode(2'b00);
    for (int n = 1; n <= 8; n++) begin
      for (int i = 0; i < n; i++) pl[i] = 8'(n * 29 + i * 71);
      if (n > 1) pl[1] = 8'hFF;
      if (n > 2) pl[2] = 8'h7E;
      clr();
      send_frame(n, 1'b1, 16'h0000);
      check_frame("R5_R4", n, 0);
    end

    pl[0] = 8'h11; pl[1] = 8'hF8; pl[2] = 8'h3F;
    clr(); send_frame(3, 1'b1, 16'h0100);
    check_frame("R6", 3, 1);

    set_mode(2'b01);
    pl[0] = 8'hFE; pl[1] = 8'h7E; pl[2] = 8'h00; pl[3] = 8'h1F; pl[4] = 8'hC3;
    clr(); send_frame(5, 1'b0, 16'h0000);
    check_frame("R7", 5, 0);
    clr(); send_frame(1, 1'b0, 16'h0000);
    check_frame("R7", 1, 0);

    // R3 empty frames and shared zero between flags
    clr();
    tx_flag(); tx_flag(); tx_flag(); idle(2);
    chk("R3", "flags only write nothing", qn, 0);
    clr();
    tx_flag(); tx_raw(8'h3F, 7); tx_ones = 0;
    tx_byte(8'h5A); tx_flag(); idle(2);
    chk("R3", "shared-zero frame count", qn, 1);
    chk("R3", "shared-zero data", qd[0], 8'h5A);

    // R9 ragged and short
    clr();
    tx_flag(); tx_byte(8'h55); sb(1'b1); sb(1'b0); sb(1'b1); tx_flag(); idle(2);
    chk("R9", "ragged count", qn, 1);
    chk("R9", "ragged data", qd[0], 0);
    chk("R9", "ragged eof", qe[0], 1);
    chk("R9", "ragged stat", qs[0], 3);

    set_mode(2'b00);
    pl[0] = 8'h12; pl[1] = 8'h34;
    clr(); send_frame(2, 1'b0, 16'h0000);
    chk("R9", "short count", qn, 1);
    chk("R9", "short stat", qs[0], 3);
    chk("R9", "short data", qd[0], 0);

    // R8 abort and recovery
    clr();
    tx_flag(); tx_byte(8'h12); tx_byte(8'h34);
    for (int i = 0; i < 8; i++) sb(1'b1);
    idle(2);
    chk("R8", "abort count", qn, 1);
    chk("R8", "abort stat", qs[0], 2);
    chk("R8", "abort data", qd[0], 0);
    chk("R8", "abort eof", qe[0], 1);
    chk("R8", "abort event", nfr, 1);
    pl[0] = 8'hA7; pl[1] = 8'h09;
    clr(); send_frame(2, 1'b1, 16'h0000);
    check_frame("R8", 2, 0);

    // R10 overflow
    set_mode(2'b10); clr();
    fifo_full = 1'b1;
    tx_raw(8'hAA, 8); tx_raw(8'h55, 8); idle(2);
    fifo_full = 1'b0;
    chk("R10", "overflow events", novf, 2);
    chk("R10", "no writes when full", qn, 0);

    // R11 disable
    clr();
    rx_en = 1'b0;
    tx_raw(8'hF0, 8); tx_raw(8'h0F, 8); idle(2);
    chk("R11", "no writes while disabled", qn, 0);
    rx_en = 1'b1;
    tx_raw(8'hFF, 4);
    rx_en = 1'b0; idle(1); rx_en = 1'b1;
    tx_raw(8'hA5, 8); idle(2);
    chk("R11", "count after re-enable", qn, 1);
    chk("R11", "partial bits discarded", qd[0], 8'hA5);

    report();
  end
endmodule